// File: doc/BRIEF.md
# Four-Bank DRAM Address Multiplexer with Internal Refresh

This block sits between a processor memory port and up to four banks of 64K-deep DRAM. An 18-bit processor address arrives as a 16-bit in-bank address plus a 2-bit bank number. The block turns each request into a RAS/CAS cycle on an 8-bit multiplexed address bus. The upper address byte goes out as the row and the lower byte as the column. The bank number selects which one of four RAS strobes falls. Bank size is fixed at 64K locations. Denser devices cannot be configured in.

Refresh needs no DMA channel. A free-running timer raises a refresh request every `REF_PERIOD` clocks. The request is sticky until served. The sequencer then runs a RAS-only cycle on all four banks at once, using an internal 8-bit row counter. A processor access that has already started always finishes first. A pending refresh is served before the next access is granted.

The processor holds `req_i`, `we_i`, `addr_i` and `bank_i` steady until `ack_o` pulses for one clock, then drops `req_i`.

Top module: `dram_bank_mux`

## Requirements
- R1: While `rst_ni` is low, all four `ras_no` lines, `cas_no` and `we_no` are high and `ack_o` is low.
- R2: During a processor access, exactly one `ras_no` bit is low. It is bit `bank_i`, so bank 0 drives `ras_no[0]` and bank 3 drives `ras_no[3]`.
- R3: In the first cycle of an access, `dram_addr_o` carries `addr_i[15:8]` (the row) and `cas_no` is still high.
- R4: In the very next cycle, `dram_addr_o` switches to `addr_i[7:0]` (the column) and `cas_no` goes low, with the same RAS still low.
- R5: `cas_no` stays low for exactly `CAS_CYC` clocks (default 2). In the following cycle all RAS lines and `cas_no` are high and `ack_o` is high for that one cycle.
- R6: On a write (`we_i`=1), `we_no` is low from the row cycle onward, so it falls before CAS, and it stays low until CAS rises. On a read, `we_no` stays high.
- R7: A refresh request arises every `REF_PERIOD` clocks (default 64). Consecutive refresh cycles start at most `REF_PERIOD + CAS_CYC + 3` clocks apart. A refresh drives all four `ras_no` low for exactly `REF_CYC` clocks (default 3), with `cas_no` and `we_no` high.
- R8: During a refresh, `dram_addr_o` shows the refresh row. That row is 0 for the first refresh after reset, goes up by one after each refresh, and wraps from 255 to 0.
- R9: A refresh never starts while any RAS is low for an access, so an access in progress always completes. A refresh pending when the block goes idle runs before the next access is granted, even while `req_i` stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Memory request, held until `ack_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | In-bank address: row in [15:8], column in [7:0] |
| bank_i | input | 2 | Bank number |
| ack_o | output | 1 | One-cycle completion pulse |
| dram_addr_o | output | 8 | Multiplexed row/column/refresh-row address |
| ras_no | output | 4 | Per-bank row strobe, active low |
| cas_no | output | 1 | Shared column strobe, active low |
| we_no | output | 1 | Write enable, active low |

## Verification
The assertions assume that the processor keeps its request and its qualifiers stable from assertion until the acknowledge, and lowers the request in the acknowledge cycle. The refresh checks assume `REF_CYC + 1` is well below `REF_PERIOD`. The bench always drives a whole access through one task that sets the request together with the address, bank and direction, and releases the request only when the acknowledge is seen. Random idle gaps and fully back-to-back runs stay within these rules while still making refresh collide with accesses at every phase.

// File: rtl/drc_pkg.sv
`timescale 1ns/1ps
package drc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_DONE,
    ST_REF,
    ST_PRE
  } drc_state_e;
endpackage

// File: rtl/drc_ref_timer.sv
`timescale 1ns/1ps
module drc_ref_timer #(
  parameter int REF_PERIOD = 64,
  parameter int ROW_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             done_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int TW = (REF_PERIOD > 2) ? $clog2(REF_PERIOD) : 1;

  logic [TW-1:0]    cnt_q;
  logic             pend_q;
  logic [ROW_W-1:0] row_q;
  logic             tick;

  assign tick = (cnt_q == TW'(REF_PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      // a new tick wins over a grant in the same cycle
      if (tick)        pend_q <= 1'b1;
      else if (take_i) pend_q <= 1'b0;
      if (done_i) row_q <= row_q + 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign row_o  = row_q;

  p_row_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_q != $past(row_q)) |-> (row_q == $past(row_q) + 1'b1));

  p_pend_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !take_i) |=> pend_q);
endmodule

// File: rtl/drc_ras_dec.sv
`timescale 1ns/1ps
module drc_ras_dec #(
  parameter int BANK_W = 2,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic              en_i,
  input  logic              all_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [NBANK-1:0]  ras_no
);
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign ras_no[g] = !(all_i || (en_i && (bank_i == BANK_W'(g))));
  end
endmodule

// File: rtl/drc_seq.sv
`timescale 1ns/1ps
module drc_seq
  import drc_pkg::*;
#(
  parameter int ROW_W   = 8,
  parameter int BANK_W  = 2,
  parameter int CAS_CYC = 2,
  parameter int REF_CYC = 3,
  localparam int ADDR_W = 2 * ROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              ref_pend_i,
  input  logic [ROW_W-1:0]  ref_row_i,
  output logic              ref_take_o,
  output logic              ref_done_o,
  output logic              ack_o,
  output logic [ROW_W-1:0]  dram_addr_o,
  output logic              ras_en_o,
  output logic              ras_all_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              cas_no,
  output logic              we_no
);
  localparam int MAXC = (CAS_CYC > REF_CYC) ? CAS_CYC : REF_CYC;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

  drc_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q;
  logic [BANK_W-1:0] bank_q;
  logic              wr_q;
  logic              grant;

  assign grant = (st_q == ST_IDLE) && !ref_pend_i && req_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (ref_pend_i) st_d = ST_REF;
        else if (req_i) st_d = ST_ROW;
      end
      ST_ROW: begin
        st_d  = ST_COL;
        cnt_d = '0;
      end
      ST_COL: begin
        if (cnt_q == CNT_W'(CAS_CYC - 1)) st_d = ST_DONE;
        else cnt_d = cnt_q + 1'b1;
      end
      ST_DONE: st_d = ST_IDLE;
      ST_REF: begin
        if (cnt_q == CNT_W'(REF_CYC - 1)) st_d = ST_PRE;
        else cnt_d = cnt_q + 1'b1;
      end
      ST_PRE:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      bank_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (grant) begin
        addr_q <= addr_i;
        bank_q <= bank_i;
        wr_q   <= we_i;
      end
    end
  end

  always_comb begin
    unique case (st_q)
      ST_REF, ST_PRE: dram_addr_o = ref_row_i;
      ST_ROW:         dram_addr_o = addr_q[ADDR_W-1:ROW_W];
      default:        dram_addr_o = addr_q[ROW_W-1:0];
    endcase
  end

  assign ras_en_o   = (st_q == ST_ROW) || (st_q == ST_COL);
  assign ras_all_o  = (st_q == ST_REF);
  assign bank_o     = bank_q;
  assign cas_no     = (st_q != ST_COL);
  // early write: WE falls with RAS, one clock ahead of CAS
  assign we_no      = !(wr_q && ras_en_o);
  assign ack_o      = (st_q == ST_DONE);
  assign ref_take_o = (st_q == ST_IDLE) && ref_pend_i;
  assign ref_done_o = (st_q == ST_PRE);

  p_ref_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && ref_pend_i) |=> (st_q == ST_REF));

  p_col_follows_row_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ROW) |=> (!cas_no && $stable(bank_q)));
endmodule

// File: rtl/dram_bank_mux.sv
`timescale 1ns/1ps
module dram_bank_mux #(
  parameter int ROW_W      = 8,
  parameter int BANK_W     = 2,
  parameter int CAS_CYC    = 2,
  parameter int REF_CYC    = 3,
  parameter int REF_PERIOD = 64,
  localparam int ADDR_W    = 2 * ROW_W,
  localparam int NBANK     = 1 << BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              ack_o,
  output logic [ROW_W-1:0]  dram_addr_o,
  output logic [NBANK-1:0]  ras_no,
  output logic              cas_no,
  output logic              we_no
);
  logic              ref_pend, ref_take, ref_done;
  logic [ROW_W-1:0]  ref_row;
  logic              ras_en, ras_all;
  logic [BANK_W-1:0] bank_sel;

  drc_ref_timer #(
    .REF_PERIOD(REF_PERIOD),
    .ROW_W     (ROW_W)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .take_i(ref_take),
    .done_i(ref_done),
    .pend_o(ref_pend),
    .row_o (ref_row)
  );

  drc_seq #(
    .ROW_W  (ROW_W),
    .BANK_W (BANK_W),
    .CAS_CYC(CAS_CYC),
    .REF_CYC(REF_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .bank_i     (bank_i),
    .ref_pend_i (ref_pend),
    .ref_row_i  (ref_row),
    .ref_take_o (ref_take),
    .ref_done_o (ref_done),
    .ack_o      (ack_o),
    .dram_addr_o(dram_addr_o),
    .ras_en_o   (ras_en),
    .ras_all_o  (ras_all),
    .bank_o     (bank_sel),
    .cas_no     (cas_no),
    .we_no      (we_no)
  );

  drc_ras_dec #(
    .BANK_W(BANK_W)
  ) u_dec (
    .en_i  (ras_en),
    .all_i (ras_all),
    .bank_i(bank_sel),
    .ras_no(ras_no)
  );

  p_one_bank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_no |-> ($countones(~ras_no) == 1));

  p_ack_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (ras_no == '1 && cas_no && we_no));

  p_ref_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_no == '0) |-> (cas_no && we_no));

  p_early_we_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_no) |-> $stable(we_no));
endmodule

// File: tb/dram_bank_mux_bench.sv
`timescale 1ns/1ps
module dram_bank_mux_bench;
  localparam int CAS_CYC    = 2;
  localparam int REF_CYC    = 3;
  localparam int REF_PERIOD = 64;
  localparam int GAP_MAX    = REF_PERIOD + CAS_CYC + 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = '0;
  logic [1:0]  bank = '0;
  logic        ack;
  logic [7:0]  dram_addr;
  logic [3:0]  ras_n;
  logic        cas_n;
  logic        we_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dram_bank_mux #(
    .CAS_CYC   (CAS_CYC),
    .REF_CYC   (REF_CYC),
    .REF_PERIOD(REF_PERIOD)
  ) u_dram_bank_mux (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_i      (req),
    .we_i       (we),
    .addr_i     (addr),
    .bank_i     (bank),
    .ack_o      (ack),
    .dram_addr_o(dram_addr),
    .ras_no     (ras_n),
    .cas_no     (cas_n),
    .we_no      (we_n)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_ras(input logic [1:0] b);
    return ~(4'b0001 << b);
  endfunction

  // refresh monitor
  logic [3:0] prev_ras = 4'hF;
  logic [7:0] exp_row = 8'h00;
  int ref_len = 0;
  int ref_cnt = 0;
  int since_ref = -1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (since_ref >= 0) since_ref++;
      if (ras_n == 4'h0 && prev_ras != 4'h0) begin
        chk(prev_ras == 4'hF, "R9 refresh overlaps access", prev_ras, 4'hF);
        chk(dram_addr == exp_row, "R8 refresh row", dram_addr, exp_row);
        chk(cas_n && we_n, "R7 cas/we during refresh", {cas_n, we_n}, 2'b11);
        if (since_ref >= 0)
          chk(since_ref <= GAP_MAX, "R7 refresh spacing", since_ref, GAP_MAX);
        since_ref = 0;
        ref_len = 1;
      end else if (ras_n == 4'h0) begin
        ref_len++;
        chk(dram_addr == exp_row, "R8 refresh row held", dram_addr, exp_row);
      end else if (prev_ras == 4'h0) begin
        chk(ref_len == REF_CYC, "R7 refresh length", ref_len, REF_CYC);
        exp_row = exp_row + 8'd1;
        ref_cnt++;
      end
      prev_ras = ras_n;
    end
  end

  task automatic do_acc(input logic [1:0] b, input logic [15:0] a, input bit w);
    int k;
    int t;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; bank = b;
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (($countones(~ras_n) != 1) && t < 100);
    chk(t < 100, "R9 access never granted", t, 0);
    chk(ras_n == exp_ras(b), "R2 bank ras", ras_n, exp_ras(b));
    chk(dram_addr == a[15:8], "R3 row address", dram_addr, a[15:8]);
    chk(cas_n == 1'b1, "R3 cas high in row cycle", cas_n, 1);
    chk(we_n == !w, "R6 we in row cycle", we_n, !w);
    k = 0;
    forever begin
      @(negedge clk);
      if (cas_n) break;
      k++;
      chk(dram_addr == a[7:0], "R4 column address", dram_addr, a[7:0]);
      chk(ras_n == exp_ras(b), "R2 ras held", ras_n, exp_ras(b));
      chk(we_n == !w, "R6 we during cas", we_n, !w);
      if (k > 20) break;
    end
    chk(k == CAS_CYC, "R5 cas length", k, CAS_CYC);
    chk(ack == 1'b1, "R5 ack", ack, 1);
    chk(ras_n == 4'hF, "R5 ras released", ras_n, 4'hF);
    req = 1'b0;
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'h1d2c3b4a);
    repeat (3) @(negedge clk);
    chk(ras_n == 4'hF, "R1 reset ras", ras_n, 4'hF);
    chk(cas_n && we_n, "R1 reset cas/we", {cas_n, we_n}, 2'b11);
    chk(ack == 1'b0, "R1 reset ack", ack, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed: every bank, both directions, corner addresses
    for (int b = 0; b < 4; b++) begin
      do_acc(2'(b), 16'hFF00, 1'b0);
      do_acc(2'(b), 16'h00FF, 1'b1);
    end
    do_acc(2'd3, 16'hFFFF, 1'b1);
    do_acc(2'd0, 16'h0000, 1'b0);

    // back-to-back burst: refresh must slip in between accesses (R9)
    begin
      int r0;
      r0 = ref_cnt;
      for (int i = 0; i < 60; i++) do_acc(2'(i), 16'(i * 16'h0101), i[0]);
      chk(ref_cnt > r0, "R9 refresh during back-to-back", ref_cnt - r0, 1);
    end

    // random traffic, long enough to wrap the refresh row
    for (int i = 0; i < 3000; i++) begin
      int gap;
      gap = $urandom_range(0, 6);
      repeat (gap) @(negedge clk);
      do_acc(2'($urandom_range(0, 3)), 16'($urandom), 1'($urandom));
    end
    chk(ref_cnt > 256, "R8 row counter wrapped", ref_cnt, 257);

    // idle stretch: refresh alone
    repeat (4 * REF_PERIOD) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule